// File: doc/BRIEF.md
# Grouped Interrupt Priority Encoder

This block gathers interrupt requests arranged in three groups (critical, main and peripheral) and reports the single source that needs service next. The main and peripheral groups each have a mask register. Each source has its own disable bit in that register, and both registers come out of reset with a fixed default. A small write port loads either mask.

Every cycle the block builds a 32-bit encoded status word. The word has one valid flag and one source-number field per group. From the same inputs the block forms an 8-bit hardware interrupt identifier: a 2-bit group code sits above a 6-bit source number. Some peripherals can be promoted, through a high-boost vector and a medium-boost vector. A promoted peripheral shows up as a reserved code in the critical field or in the main field, and that code sends identifier formation to the peripheral field. Peripheral source 0 is the aggregated DMA task interrupt. When it is selected, the identifier reports the lowest pending DMA task index in group 3.

The status word, the identifier and its valid flag are registered. They follow the inputs with one cycle of latency.

Top module: `irq_group_encoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, status_o, irq_id_o and irq_valid_o are all 0.
- R2: Main source n is disabled when main mask bit 16-n is 1. Peripheral source n is disabled when peripheral mask bit 31-n is 1. At reset the main mask is 0x10fff and the peripheral mask is 0x7ffffc00. When a mask write enable is high, the data is loaded at that clock edge and takes effect on the following cycle.
- R3: The critical field has its valid flag at status bit 10 and its 2-bit number at bits [9:8]. Candidate codes are 0, 1 and 3 from crit_req_i bits 0, 1 and 3. Code 2 means that an unmasked high-boosted peripheral is pending, and crit_req_i bit 2 is ignored. The lowest pending code is reported.
- R4: The main field has its valid flag at status bit 21 and its 5-bit number at bits [20:16]. The lowest-numbered unmasked pending source is reported. Slot 4 is set by an unmasked medium-boosted peripheral that is not also high-boosted, gated by main mask bit 12, and main_req_i bit 4 is ignored.
- R5: The peripheral field has its valid flag at status bit 29 and its number at bits [28:24]. Valid means that any unmasked peripheral is pending. The number is the lowest pending high-boosted source, or failing that the lowest pending medium-boosted source, or failing that the lowest pending source.
- R6: All status bits outside the three fields are 0, and the number of a field that is not valid is 0.
- R7: Precedence is critical, then main, then peripheral. The identifier is (group << 6) | source, with group code 0 for critical, 1 for main, 2 for peripheral and 3 for DMA task.
- R8: A critical number of 2, or a main number of 4 when the critical field is not valid, selects the peripheral field for the identifier.
- R9: When the peripheral field selected for the identifier holds number 0, the identifier is group 3 with the lowest set bit index of dma_pend_i. If no DMA task is pending, the source part is 0x3f.
- R10: When no field is valid, irq_valid_o is 0 and irq_id_o is 0. Otherwise irq_valid_o is 1.
- R11: Changes on the request, boost and DMA inputs appear on the outputs one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crit_req_i | input | 4 | Critical requests; bit 2 unused |
| main_req_i | input | 17 | Main group requests; bit 4 unused |
| per_req_i | input | 32 | Peripheral group requests |
| hi_boost_i | input | 32 | Peripherals promoted to the critical level |
| mid_boost_i | input | 32 | Peripherals promoted to the main level |
| dma_pend_i | input | 16 | Pending DMA task interrupts |
| main_mask_we_i | input | 1 | Main mask load enable |
| main_mask_d_i | input | 17 | Main mask load data |
| per_mask_we_i | input | 1 | Peripheral mask load enable |
| per_mask_d_i | input | 32 | Peripheral mask load data |
| status_o | output | 32 | Encoded status word |
| irq_id_o | output | 8 | Hardware interrupt identifier |
| irq_valid_o | output | 1 | Identifier valid |

## Verification
The assertions check on every cycle the relations between the registered outputs. Valid agrees with the three field flags, an idle identifier is zero, a non-redirected critical or main winner forms its own identifier, and a redirect code always comes with a valid peripheral field. They also check the one-cycle latency of the critical flag and the loading of the mask registers. The bench scenarios are the only way to show the reset mask defaults, the mask bit ordering and the ignored request bits. The same holds for the boost ordering inside the peripheral field, the DMA index substitution and its empty case, and the precedence between groups when several of them are pending together.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int GRP_W  = 2;
  localparam int SRC_W  = 6;
  localparam int ID_W   = GRP_W + SRC_W;
  localparam int NUM_W  = 5;
  localparam int CRIT_N = 4;
  localparam int STAT_W = 32;

  localparam int CRIT_VLD_BIT = 10;
  localparam int CRIT_NUM_LSB = 8;
  localparam int MAIN_VLD_BIT = 21;
  localparam int MAIN_NUM_LSB = 16;
  localparam int PER_VLD_BIT  = 29;
  localparam int PER_NUM_LSB  = 24;

  // reserved codes that stand for a promoted peripheral
  localparam int CRIT_PROMO = 2;
  localparam int MAIN_PROMO = 4;

  typedef enum logic [GRP_W-1:0] {
    GRP_CRIT = 2'd0,
    GRP_MAIN = 2'd1,
    GRP_PER  = 2'd2,
    GRP_DMA  = 2'd3
  } grp_e;
endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] vec_i,
  output logic         hit_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    hit_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int          W   = 32,
  parameter logic [W-1:0] RST = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= d_i;
  end

  // R2: a load lands on the next edge
  a_r2_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(we_i) |-> q_o == $past(d_i));
endmodule

// File: rtl/irq_per_select.sv
module irq_per_select import irq_enc_pkg::*; #(
  parameter int PER_N = 32
) (
  input  logic [PER_N-1:0] pend_i,
  input  logic [PER_N-1:0] hi_i,
  input  logic [PER_N-1:0] mid_i,
  output logic             hi_hit_o,
  output logic             mid_hit_o,
  output logic             vld_o,
  output logic [NUM_W-1:0] num_o
);
  logic [PER_N-1:0] hi_vec, mid_vec;
  logic [NUM_W-1:0] hi_idx, mid_idx, any_idx;

  assign hi_vec  = pend_i & hi_i;
  assign mid_vec = pend_i & mid_i & ~hi_i;

  irq_first_set #(.N(PER_N), .W(NUM_W)) i_hi (
    .vec_i(hi_vec), .hit_o(hi_hit_o), .idx_o(hi_idx));
  irq_first_set #(.N(PER_N), .W(NUM_W)) i_mid (
    .vec_i(mid_vec), .hit_o(mid_hit_o), .idx_o(mid_idx));
  irq_first_set #(.N(PER_N), .W(NUM_W)) i_any (
    .vec_i(pend_i), .hit_o(vld_o), .idx_o(any_idx));

  always_comb begin
    if (hi_hit_o)       num_o = hi_idx;
    else if (mid_hit_o) num_o = mid_idx;
    else                num_o = any_idx;
  end
endmodule

// File: rtl/irq_id_merge.sv
module irq_id_merge import irq_enc_pkg::*; #(
  parameter int DMA_W = 4
) (
  input  logic             crit_vld_i,
  input  logic [1:0]       crit_num_i,
  input  logic             main_vld_i,
  input  logic [NUM_W-1:0] main_num_i,
  input  logic             per_vld_i,
  input  logic [NUM_W-1:0] per_num_i,
  input  logic             dma_hit_i,
  input  logic [DMA_W-1:0] dma_idx_i,
  output logic [ID_W-1:0]  id_o,
  output logic             vld_o
);
  logic [SRC_W-1:0] dma_src;
  logic [ID_W-1:0]  per_id;

  assign dma_src = dma_hit_i ? SRC_W'(dma_idx_i) : '1;
  assign per_id  = (per_num_i == '0) ? {GRP_DMA, dma_src}
                                     : {GRP_PER, 1'b0, per_num_i};

  always_comb begin
    vld_o = 1'b1;
    if (crit_vld_i) begin
      id_o = (crit_num_i == 2'(CRIT_PROMO)) ? per_id
                                            : {GRP_CRIT, 4'b0, crit_num_i};
    end else if (main_vld_i) begin
      id_o = (main_num_i == NUM_W'(MAIN_PROMO)) ? per_id
                                                : {GRP_MAIN, 1'b0, main_num_i};
    end else if (per_vld_i) begin
      id_o = per_id;
    end else begin
      id_o  = '0;
      vld_o = 1'b0;
    end
  end
endmodule

// File: rtl/irq_group_encoder.sv
module irq_group_encoder import irq_enc_pkg::*; #(
  parameter int          MAIN_N        = 17,
  parameter int          PER_N         = 32,
  parameter int          DMA_N         = 16,
  parameter logic [31:0] MAIN_MASK_RST = 32'h0001_0fff,
  parameter logic [31:0] PER_MASK_RST  = 32'h7fff_fc00
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CRIT_N-1:0]    crit_req_i,
  input  logic [MAIN_N-1:0]    main_req_i,
  input  logic [PER_N-1:0]     per_req_i,
  input  logic [PER_N-1:0]     hi_boost_i,
  input  logic [PER_N-1:0]     mid_boost_i,
  input  logic [DMA_N-1:0]     dma_pend_i,
  input  logic                 main_mask_we_i,
  input  logic [MAIN_N-1:0]    main_mask_d_i,
  input  logic                 per_mask_we_i,
  input  logic [PER_N-1:0]     per_mask_d_i,
  output logic [STAT_W-1:0]    status_o,
  output logic [ID_W-1:0]      irq_id_o,
  output logic                 irq_valid_o
);
  localparam int DMA_W = (DMA_N > 1) ? $clog2(DMA_N) : 1;

  logic [MAIN_N-1:0] main_mask_q, main_en, main_eff;
  logic [PER_N-1:0]  per_mask_q, per_en, per_pend;
  logic [CRIT_N-1:0] crit_eff;

  irq_mask_reg #(.W(MAIN_N), .RST(MAIN_MASK_RST[MAIN_N-1:0])) i_main_mask (
    .clk_i, .rst_ni, .we_i(main_mask_we_i), .d_i(main_mask_d_i), .q_o(main_mask_q));
  irq_mask_reg #(.W(PER_N), .RST(PER_MASK_RST[PER_N-1:0])) i_per_mask (
    .clk_i, .rst_ni, .we_i(per_mask_we_i), .d_i(per_mask_d_i), .q_o(per_mask_q));

  // mask bit order is reversed against source number
  for (genvar n = 0; n < MAIN_N; n++) begin : g_main_en
    assign main_en[n] = ~main_mask_q[MAIN_N-1-n];
  end
  for (genvar n = 0; n < PER_N; n++) begin : g_per_en
    assign per_en[n] = ~per_mask_q[PER_N-1-n];
  end

  assign per_pend = per_req_i & per_en;

  logic             hi_hit, mid_hit, per_vld;
  logic [NUM_W-1:0] per_num;

  irq_per_select #(.PER_N(PER_N)) i_per_sel (
    .pend_i(per_pend), .hi_i(hi_boost_i), .mid_i(mid_boost_i),
    .hi_hit_o(hi_hit), .mid_hit_o(mid_hit), .vld_o(per_vld), .num_o(per_num));

  always_comb begin
    crit_eff             = crit_req_i;
    crit_eff[CRIT_PROMO] = hi_hit;
    main_eff             = main_req_i & main_en;
    main_eff[MAIN_PROMO] = mid_hit & main_en[MAIN_PROMO];
  end

  logic             crit_vld, main_vld, dma_hit;
  logic [1:0]       crit_num;
  logic [NUM_W-1:0] main_num;
  logic [DMA_W-1:0] dma_idx;

  irq_first_set #(.N(CRIT_N), .W(2)) i_crit_enc (
    .vec_i(crit_eff), .hit_o(crit_vld), .idx_o(crit_num));
  irq_first_set #(.N(MAIN_N), .W(NUM_W)) i_main_enc (
    .vec_i(main_eff), .hit_o(main_vld), .idx_o(main_num));
  irq_first_set #(.N(DMA_N), .W(DMA_W)) i_dma_enc (
    .vec_i(dma_pend_i), .hit_o(dma_hit), .idx_o(dma_idx));

  logic [ID_W-1:0]   id_d;
  logic              vld_d;
  logic [STAT_W-1:0] status_d;

  irq_id_merge #(.DMA_W(DMA_W)) i_merge (
    .crit_vld_i(crit_vld), .crit_num_i(crit_num),
    .main_vld_i(main_vld), .main_num_i(main_num),
    .per_vld_i(per_vld),   .per_num_i(per_num),
    .dma_hit_i(dma_hit),   .dma_idx_i(dma_idx),
    .id_o(id_d), .vld_o(vld_d));

  always_comb begin
    status_d                                  = '0;
    status_d[CRIT_VLD_BIT]                    = crit_vld;
    status_d[CRIT_NUM_LSB +: 2]               = crit_num;
    status_d[MAIN_VLD_BIT]                    = main_vld;
    status_d[MAIN_NUM_LSB +: NUM_W]           = main_num;
    status_d[PER_VLD_BIT]                     = per_vld;
    status_d[PER_NUM_LSB +: NUM_W]            = per_num;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o    <= '0;
      irq_id_o    <= '0;
      irq_valid_o <= 1'b0;
    end else begin
      status_o    <= status_d;
      irq_id_o    <= id_d;
      irq_valid_o <= vld_d;
    end
  end

  // R10
  a_r10_vld_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o == (status_o[CRIT_VLD_BIT] | status_o[MAIN_VLD_BIT] | status_o[PER_VLD_BIT]));
  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_o |-> irq_id_o == '0);
  // R7
  a_r7_crit_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[CRIT_VLD_BIT] && status_o[CRIT_NUM_LSB +: 2] != 2'(CRIT_PROMO)
    |-> irq_id_o == {GRP_CRIT, 4'b0, status_o[CRIT_NUM_LSB +: 2]});
  a_r7_main_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[CRIT_VLD_BIT] && status_o[MAIN_VLD_BIT] &&
    status_o[MAIN_NUM_LSB +: NUM_W] != NUM_W'(MAIN_PROMO)
    |-> irq_id_o == {GRP_MAIN, 1'b0, status_o[MAIN_NUM_LSB +: NUM_W]});
  // R8
  a_r8_crit_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[CRIT_VLD_BIT] && status_o[CRIT_NUM_LSB +: 2] == 2'(CRIT_PROMO)
    |-> status_o[PER_VLD_BIT] && irq_id_o[ID_W-1]);
  a_r8_main_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[CRIT_VLD_BIT] && status_o[MAIN_VLD_BIT] &&
    status_o[MAIN_NUM_LSB +: NUM_W] == NUM_W'(MAIN_PROMO)
    |-> status_o[PER_VLD_BIT] && irq_id_o[ID_W-1]);
  // R11
  a_r11_crit_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> status_o[CRIT_VLD_BIT] ==
    $past(crit_req_i[3] | crit_req_i[1] | crit_req_i[0] | hi_hit));
endmodule

// File: tb/test_irq_group_encoder.sv
`timescale 1ns/100ps
module test_irq_group_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  crit = '0;
  logic [16:0] mreq = '0;
  logic [31:0] preq = '0, hib = '0, midb = '0;
  logic [15:0] dma = '0;
  logic        mwe = 1'b0, pwe = 1'b0;
  logic [16:0] md = '0;
  logic [31:0] pd = '0;
  logic [31:0] status;
  logic [7:0]  id;
  logic        vld;

  logic [16:0] mmask = 17'h10fff;
  logic [31:0] pmask = 32'h7fff_fc00;

  int total = 0, fails = 0;

  typedef struct {
    logic [31:0] st;
    logic [7:0]  id;
    logic        v;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  irq_group_encoder i_irq_group_encoder (
    .clk_i(clk), .rst_ni(rst_n),
    .crit_req_i(crit), .main_req_i(mreq), .per_req_i(preq),
    .hi_boost_i(hib), .mid_boost_i(midb), .dma_pend_i(dma),
    .main_mask_we_i(mwe), .main_mask_d_i(md),
    .per_mask_we_i(pwe), .per_mask_d_i(pd),
    .status_o(status), .irq_id_o(id), .irq_valid_o(vld));

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model built from the requirement text
  function automatic exp_t model(string tag);
    exp_t e;
    int an = -1, hn = -1, mn = -1, cn = -1, mainn = -1, pnum, dn = -1;
    logic [5:0] dsrc;
    logic [7:0] pid;
    for (int n = 0; n < 32; n++) begin
      if (preq[n] && !pmask[31-n]) begin
        if (an < 0) an = n;
        if (hib[n] && hn < 0) hn = n;
        if (midb[n] && !hib[n] && mn < 0) mn = n;
      end
    end
    pnum = (hn >= 0) ? hn : (mn >= 0) ? mn : (an >= 0) ? an : 0;
    for (int c = 0; c < 4; c++) begin
      if (cn < 0 && ((c == 2) ? (hn >= 0) : crit[c])) cn = c;
    end
    for (int n = 0; n < 17; n++) begin
      if (mainn < 0 && !mmask[16-n] && ((n == 4) ? (mn >= 0) : mreq[n])) mainn = n;
    end
    for (int d = 0; d < 16; d++) if (dma[d] && dn < 0) dn = d;
    dsrc = (dn >= 0) ? 6'(dn) : 6'h3f;
    pid  = (pnum == 0) ? {2'd3, dsrc} : {2'd2, 6'(pnum)};
    e.st = '0;
    if (cn >= 0)    begin e.st[10] = 1'b1; e.st[9:8]   = 2'(cn);    end
    if (mainn >= 0) begin e.st[21] = 1'b1; e.st[20:16] = 5'(mainn); end
    if (an >= 0)    begin e.st[29] = 1'b1; e.st[28:24] = 5'(pnum);  end
    e.v = 1'b1;
    if (cn >= 0)         e.id = (cn == 2) ? pid : {2'd0, 6'(cn)};
    else if (mainn >= 0) e.id = (mainn == 4) ? pid : {2'd1, 6'(mainn)};
    else if (an >= 0)    e.id = pid;
    else begin e.id = '0; e.v = 1'b0; end
    e.tag = tag;
    return e;
  endfunction

  task automatic apply(logic [3:0] c, logic [16:0] m, logic [31:0] p,
                       logic [31:0] h, logic [31:0] mi, logic [15:0] d, string tag);
    @(negedge clk);
    crit = c; mreq = m; preq = p; hib = h; midb = mi; dma = d;
    q.push_back(model(tag));
  endtask

  task automatic load_masks(logic [16:0] m, logic [31:0] p);
    @(negedge clk);
    mwe = 1'b1; md = m; pwe = 1'b1; pd = p;
    mmask = m; pmask = p;
    @(negedge clk);
    mwe = 1'b0; pwe = 1'b0;
  endtask

  // monitor: compare one cycle after each drive
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "status", status, e.st);
      check(e.tag, "id", 32'(id), 32'(e.id));
      check(e.tag, "valid", 32'(vld), 32'(e.v));
    end
  end

  initial begin
    #100000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "status in reset", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "status", status, 0);
    check("R1", "id", 32'(id), 0);
    check("R1", "valid", 32'(vld), 0);

    apply(4'b0001, '0, '0, '0, '0, '0, "R3_crit0");
    apply(4'b1000, '0, '0, '0, '0, '0, "R3_crit3");
    apply(4'b0100, '0, '0, '0, '0, '0, "R3_crit2_ignored");
    apply('0, '1, '0, '0, '0, '0, "R2_main_reset_mask");
    apply(4'b0010, 17'h00004, '0, '0, '0, '0, "R7_crit_over_main");
    apply('0, 17'h00010, '0, '0, '0, '0, "R4_main4_ignored");
    apply('0, '0, 32'h0040_0000, '0, '0, '0, "R5_per22");
    apply('0, '0, 32'h0000_0020, '0, '0, '0, "R2_per5_masked");
    apply('0, '0, 32'h0000_0001, '0, '0, 16'h0030, "R9_dma_idx");
    apply('0, '0, 32'h0000_0001, '0, '0, '0, "R9_dma_empty");
    apply('0, 17'h00008, 32'h0040_0000, '0, '0, '0, "R7_main_over_per");
    apply('0, '0, '0, '0, '0, '0, "R10_idle");
    apply('0, '0, 32'h0040_0000, '0, 32'h0040_0000, '0, "R11_toggle_on");
    apply('0, '0, '0, '0, 32'h0040_0000, '0, "R11_toggle_off");

    load_masks(17'h00000, 32'h0000_0000);
    apply('0, 17'h00001, '0, '0, '0, '0, "R2_main0_unmasked");
    apply('0, '0, 32'h0000_0088, '0, 32'h0000_0080, '0, "R8_mid_redirect");
    apply('0, '0, 32'h0000_0208, 32'h0000_0200, '0, '0, "R8_hi_redirect");
    apply(4'b0001, '0, 32'h0000_0208, 32'h0000_0200, '0, '0, "R7_crit_over_hi");
    apply('0, 17'h00002, 32'h0000_0088, '0, 32'h0000_0080, '0, "R4_main1_over_mid");
    apply('0, '0, 32'h0000_0289, 32'h0000_0200, 32'h0000_0081, 16'h8000, "R5_hi_first");
    apply('0, '0, 32'h0000_0081, '0, 32'h0000_0081, 16'h8000, "R9_mid_dma");
    apply('0, '0, 32'h0000_00c0, 32'h0000_0080, 32'h0000_0080, '0, "R5_hi_and_mid");

    load_masks(17'h10000, 32'hffff_ffff);
    apply('0, 17'h00001, 32'hffff_ffff, '1, '1, '0, "R2_all_masked");
    load_masks(17'h00001, 32'h0000_0000);
    apply('0, 17'h10000, '0, '0, '0, '0, "R2_main16_masked");
    apply('0, 17'h18000, '0, '0, '0, '0, "R6_main15");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule